// File: doc/BRIEF.md
# Hashed Multicast Receive Address Filter

This block decides, for each received Ethernet frame, whether the frame is kept or dropped. The decision rests on the frame's 48-bit destination address alone. The address is compared against a programmable station address and against the all-ones broadcast address. A multicast address is looked up in a 512-bit hash table, indexed by a CRC-32 residue of the address.

A control port holds three registers: an indirect index, an indirect data word and an accept-mode word. Writing the data word stores its low 16 bits at the location named by the index. That location is either one third of the station address or one of the 32 words of the hash table.

Destination bytes arrive one per cycle on a byte strobe. A start strobe marks the first byte. One cycle after the sixth byte, the block raises a one-cycle decision pulse that carries the accept or reject outcome.

The control is a three-state machine:
- ST_IDLE waits for a start.
- ST_COLLECT gathers bytes two to six. It moves to ST_DECIDE on the sixth byte, and returns to its own first byte when a new start arrives.
- ST_DECIDE presents the outcome for one cycle. It then goes back to ST_IDLE, or straight into ST_COLLECT when a start arrives in that cycle.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset, `dec_valid` is low. The station address, the hash table and the mode word are all zero, so every frame is rejected.
- R2: A byte is taken when `byte_vld` is high. `frm_start` together with `byte_vld` marks address byte 0, the first byte on the wire. Bytes 1 to 5 follow with `byte_vld`, and idle cycles may appear between them. A frame is multicast when bit 0 of byte 0 is 1.
- R3: `dec_valid` is high for exactly one cycle, the cycle right after the clock edge that takes byte 5. `dec_accept` is valid only in that cycle and is low otherwise.
- R4: A start strobe that arrives before six bytes have been taken abandons the current address, and no decision is made for it. The strobe's own byte becomes byte 0 of a new address.
- R5: `cfg_sel`=0 writes the indirect index (10 bits of `cfg_wdata`). `cfg_sel`=1 writes the low 16 bits of `cfg_wdata` to the indexed location. Index 0, 2 and 4 load station bytes {1,0}, {3,2} and {5,4}, with the lower-numbered byte in bits 7:0. Other unlisted indices are ignored.
- R6: When mode bit 27 (own address) is set, a non-broadcast, non-multicast address equal to the station address is accepted.
- R7: The all-ones address is accepted exactly when mode bit 31 or bit 30 is set (broadcast value 0xC0000000), unless bit 28 is set. The hash table is not consulted for it.
- R8: With mode bit 21 set, a multicast, non-broadcast address is accepted when table bit n is 1. Here n is the low 9 bits of a CRC-32 over bytes 0..5, taken bit 0 first, with the reflected polynomial 0xEDB88320, a start value of 0xFFFFFFFF and no final inversion.
- R9: Index 0x200+2*w loads hash-table word w (w = 0..31). Table bit n lives in word n/16 at bit n%16.
- R10: Mode bit 29 accepts every multicast, non-broadcast address.
- R11: Mode bit 28 accepts every address. The promiscuous setting 0xF8000000 sets bits 31..27 together.
- R12: `cfg_sel`=2 writes the 32-bit mode word. The mode is captured with byte 0 of a frame, so a write during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_sel | input | 2 | 0 index, 1 indirect data, 2 mode word |
| cfg_wdata | input | 32 | Control write data |
| frm_start | input | 1 | Marks address byte 0 (with byte_vld) |
| byte_vld | input | 1 | Address byte strobe |
| byte_data | input | 8 | Address byte |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Frame accepted (valid with dec_valid) |

## Verification
A wrong byte counter or a state machine stuck in the wrong state shows up as a decision pulse that comes early, comes late, or never comes. The bench catches this on the very next frame, because each pulse is matched against the cycle in which the sixth byte was driven.

A corrupted CRC register or a misplaced table word does not fail every frame. It flips the outcome only for multicast addresses whose index lands on the affected bits. For that reason the whole table is filled with a non-uniform pattern and several multicast addresses are checked.

A mode register that is sampled at the wrong moment shows up only when a mode write falls inside a frame, so that case is driven on purpose.

// File: rtl/mf_pkg.sv
package mf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int MODE_W     = 32;

    // accept-mode bit positions (decoded by the decision logic)
    localparam int MB_BCAST_HI = 31;
    localparam int MB_BCAST_LO = 30;
    localparam int MB_ALL_MC   = 29;
    localparam int MB_ALL_PHY  = 28;
    localparam int MB_OWN_PHY  = 27;
    localparam int MB_HASH_MC  = 21;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_MODE  = 2'd2
    } cfg_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2
    } fsm_state_t;

    function automatic logic [31:0] crc_byte_step(input logic [31:0] c,
                                                  input logic [7:0]  b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/mf_cfg_regs.sv
module mf_cfg_regs
    import mf_pkg::*;
#(
    parameter int          HASH_BITS  = 512,
    parameter int          WORD_W     = 16,
    parameter int          IDX_W      = 10,
    parameter int          TABLE_BASE = 'h200
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [1:0]             cfg_sel,
    input  logic [31:0]            cfg_wdata,
    output logic [8*ADDR_BYTES-1:0] station,
    output logic [HASH_BITS-1:0]   table_bits,
    output logic [MODE_W-1:0]      mode_word
);

    localparam int NWORDS   = HASH_BITS / WORD_W;
    localparam int STA_WRDS = (8 * ADDR_BYTES) / WORD_W;

    logic [IDX_W-1:0] idx_q;
    logic             wr_idx, wr_data, wr_mode;

    always_comb begin
        wr_idx  = cfg_wr && (cfg_sel == SEL_INDEX);
        wr_data = cfg_wr && (cfg_sel == SEL_DATA);
        wr_mode = cfg_wr && (cfg_sel == SEL_MODE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            mode_word <= '0;
        end else begin
            if (wr_idx)  idx_q     <= cfg_wdata[IDX_W-1:0];
            if (wr_mode) mode_word <= cfg_wdata[MODE_W-1:0];
        end
    end

    // station address words at even indices 0, 2, 4
    for (genvar g = 0; g < STA_WRDS; g++) begin : g_sta
        always_ff @(posedge clk) begin
            if (!rst_n)
                station[g*WORD_W +: WORD_W] <= '0;
            else if (wr_data && (idx_q == IDX_W'(2*g)))
                station[g*WORD_W +: WORD_W] <= cfg_wdata[WORD_W-1:0];
        end
    end

    // hash table words at TABLE_BASE + 2*w
    for (genvar w = 0; w < NWORDS; w++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (!rst_n)
                table_bits[w*WORD_W +: WORD_W] <= '0;
            else if (wr_data && (idx_q == IDX_W'(TABLE_BASE + 2*w)))
                table_bits[w*WORD_W +: WORD_W] <= cfg_wdata[WORD_W-1:0];
        end
    end

    assert_station_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && idx_q == IDX_W'(4)) |=> station[47:32] == $past(cfg_wdata[15:0]));

    assert_table_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && idx_q == IDX_W'(TABLE_BASE)) |=> table_bits[WORD_W-1:0] == $past(cfg_wdata[WORD_W-1:0]));

endmodule

// File: rtl/mf_crc_hash.sv
module mf_crc_hash
    import mf_pkg::*;
#(
    parameter int HASH_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_first,
    input  logic              take_next,
    input  logic [7:0]        byte_in,
    output logic [HASH_W-1:0] hash_idx
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            crc_q <= CRC_INIT;
        else if (take_first)
            crc_q <= crc_byte_step(CRC_INIT, byte_in);
        else if (take_next)
            crc_q <= crc_byte_step(crc_q, byte_in);
    end

    always_comb hash_idx = crc_q[HASH_W-1:0];

    assert_crc_holds_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_first && !take_next) |=> $stable(crc_q));

endmodule

// File: rtl/mf_frame_fsm.sv
module mf_frame_fsm
    import mf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frm_start,
    input  logic                    byte_vld,
    input  logic [7:0]              byte_data,
    input  logic [MODE_W-1:0]       mode_in,
    output fsm_state_t              st_q,
    output logic                    take_first,
    output logic                    take_next,
    output logic [8*ADDR_BYTES-1:0] da_q,
    output logic [MODE_W-1:0]       mode_lat
);

    localparam int CNT_W = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_BYTES - 1);

    fsm_state_t       st_d;
    logic [CNT_W-1:0] cnt_q;

    // intake strobes
    always_comb begin
        take_first = frm_start && byte_vld;
        take_next  = !take_first && byte_vld && (st_q == ST_COLLECT);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    st_d = take_first ? ST_COLLECT : ST_IDLE;
            ST_COLLECT: begin
                if (take_first)                      st_d = ST_COLLECT;
                else if (take_next && cnt_q == LAST) st_d = ST_DECIDE;
                else                                 st_d = ST_COLLECT;
            end
            ST_DECIDE:  st_d = take_first ? ST_COLLECT : ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers: byte counter, address, latched mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            da_q     <= '0;
            mode_lat <= '0;
        end else if (take_first) begin
            cnt_q         <= CNT_W'(1);
            da_q[7:0]     <= byte_data;
            mode_lat      <= mode_in;
        end else if (take_next) begin
            cnt_q                       <= cnt_q + CNT_W'(1);
            da_q[8*int'(cnt_q) +: 8]    <= byte_data;
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECIDE) |=> (st_q != ST_DECIDE));

    assert_decide_after_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DECIDE) |-> ($past(byte_vld) && !$past(frm_start)));

    assert_restart_no_decide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_first |=> (st_q == ST_COLLECT));

    assert_mode_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COLLECT && !take_first) |=> $stable(mode_lat));

endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter
    import mf_pkg::*;
#(
    parameter int HASH_BITS  = 512,
    parameter int WORD_W     = 16,
    parameter int IDX_W      = 10,
    parameter int TABLE_BASE = 'h200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        frm_start,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    output logic        dec_valid,
    output logic        dec_accept
);

    localparam int HASH_W = $clog2(HASH_BITS);
    localparam int DA_W   = 8 * ADDR_BYTES;

    logic [DA_W-1:0]      station;
    logic [HASH_BITS-1:0] table_bits;
    logic [MODE_W-1:0]    mode_word, mode_lat;
    logic [DA_W-1:0]      da_q;
    logic [HASH_W-1:0]    hash_idx;
    logic                 take_first, take_next;
    fsm_state_t           st_q;

    mf_cfg_regs #(
        .HASH_BITS (HASH_BITS),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W),
        .TABLE_BASE(TABLE_BASE)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .station   (station),
        .table_bits(table_bits),
        .mode_word (mode_word)
    );

    mf_frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_start (frm_start),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .mode_in   (mode_word),
        .st_q      (st_q),
        .take_first(take_first),
        .take_next (take_next),
        .da_q      (da_q),
        .mode_lat  (mode_lat)
    );

    mf_crc_hash #(.HASH_W(HASH_W)) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_first(take_first),
        .take_next (take_next),
        .byte_in   (byte_data),
        .hash_idx  (hash_idx)
    );

    // address classification and match terms
    logic is_bcast, is_mcast, own_hit, hash_hit;
    logic bcast_en, accept;

    always_comb begin
        is_bcast = &da_q;
        is_mcast = da_q[0];
        own_hit  = (da_q == station);
        hash_hit = table_bits[hash_idx];
        bcast_en = mode_lat[MB_BCAST_HI] | mode_lat[MB_BCAST_LO];
        if (mode_lat[MB_ALL_PHY])
            accept = 1'b1;
        else if (is_bcast)
            accept = bcast_en;
        else if (is_mcast)
            accept = mode_lat[MB_ALL_MC] | (mode_lat[MB_HASH_MC] & hash_hit);
        else
            accept = mode_lat[MB_OWN_PHY] & own_hit;
    end

    // outputs
    always_comb begin
        dec_valid  = (st_q == ST_DECIDE);
        dec_accept = dec_valid & accept;
    end

    assert_accept_only_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    assert_bcast_no_hash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (&da_q) && !mode_lat[MB_ALL_PHY] && !mode_lat[MB_BCAST_HI] && !mode_lat[MB_BCAST_LO])
        |-> !dec_accept);

    assert_allphys_accepts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && mode_lat[MB_ALL_PHY]) |-> dec_accept);

endmodule

// File: tb/mcast_addr_filter_tb_top.sv
module mcast_addr_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        frm_start = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        dec_valid, dec_accept;

    always #2.5 clk = ~clk;

    mcast_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .frm_start(frm_start), .byte_vld(byte_vld),
        .byte_data(byte_data), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench-side model of the programmed state
    logic [47:0]  m_station = '0;
    logic [511:0] m_table   = '0;
    logic [31:0]  m_mode    = '0;

    // scoreboard queues
    bit    exp_q[$];
    int    cyc_q[$];
    string tag_q[$];

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++)
            for (int i = 0; i < 8; i++) begin
                if (c[0] ^ a[8*k+i]) c = (c >> 1) ^ 32'hEDB8_8320;
                else                 c = c >> 1;
            end
        return c;
    endfunction

    function automatic bit ref_accept(logic [47:0] a, logic [31:0] md);
        if (md[28]) return 1'b1;
        if (&a) return md[31] | md[30];
        if (a[0]) return md[29] | (md[21] & m_table[ref_crc(a) & 32'h1FF]);
        return md[27] & (a == m_station);
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected decision", 1, 0);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic int    c = cyc_q.pop_front();
                automatic string t = tag_q.pop_front();
                check({t, " accept"}, dec_accept, e);
                check("R3 decision cycle", cyc, c);
            end
        end else if (rst_n) begin
            if (dec_accept !== 1'b0) check("R3 accept without valid", dec_accept, 0);
        end
    end

    task automatic pause();
        @(negedge clk);
        cfg_wr = 0; byte_vld = 0; frm_start = 0;
    endtask

    task automatic put_byte(logic [7:0] b, bit st);
        @(negedge clk);
        cfg_wr = 0; byte_vld = 1; frm_start = st; byte_data = b;
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        byte_vld = 0; frm_start = 0;
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
        if (sel == 2'd2) m_mode = d;
    endtask

    task automatic ind_write(logic [9:0] idx, logic [15:0] d);
        cfg_write(2'd0, {22'd0, idx});
        cfg_write(2'd1, {16'd0, d});
        if (idx < 6 && !idx[0]) m_station[8*idx +: 16] = d;
        if (idx >= 10'h200 && !idx[0]) m_table[16*((idx - 10'h200) >> 1) +: 16] = d;
    endtask

    task automatic send_frame(logic [47:0] a, string tag, int gap);
        exp_q.push_back(ref_accept(a, m_mode));
        tag_q.push_back(tag);
        for (int k = 0; k < 6; k++) begin
            put_byte(a[8*k +: 8], k == 0);
            if (k == 5) cyc_q.push_back(cyc + 1);
            for (int g = 0; g < gap; g++) pause();
        end
        pause();
        pause();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] sta, mc1, mc2, uc;
        sta = 48'h5544_3322_1100 | 48'h0000_0000_0002;  // byte0 = 0x02, unicast
        mc1 = 48'h0300_5E00_0001;                        // byte0 = 0x01
        mc2 = 48'hFB00_5E00_7701;
        uc  = 48'h9988_7766_5504;

        repeat (4) @(negedge clk);
        check("R1 dec_valid in reset", dec_valid, 0);
        rst_n = 1;
        pause();
        check("R1 dec_valid after reset", dec_valid, 0);

        // R1: mode zero rejects everything
        send_frame(48'hFFFF_FFFF_FFFF, "R1 bcast, zero mode", 0);
        send_frame(48'h0, "R1 zero addr == zero station, zero mode", 0);

        // R5/R6: station address and own-address match
        ind_write(10'd0, sta[15:0]);
        ind_write(10'd2, sta[31:16]);
        ind_write(10'd4, sta[47:32]);
        ind_write(10'd6, 16'hDEAD);  // unlisted index, ignored
        cfg_write(2'd2, 32'h0800_0000);
        send_frame(sta, "R6 own match", 0);
        send_frame(uc, "R6 own mismatch", 0);
        send_frame({sta[39:0], sta[47:40]}, "R5 byte order", 0);
        send_frame(sta, "R2 gaps between bytes", 2);

        // R7: broadcast
        cfg_write(2'd2, 32'h4000_0000);
        send_frame(48'hFFFF_FFFF_FFFF, "R7 bcast bit30", 0);
        cfg_write(2'd2, 32'h8000_0000);
        send_frame(48'hFFFF_FFFF_FFFF, "R7 bcast bit31", 0);

        // R8/R9: hash table, single bit then full pattern
        ind_write(10'h200 + 10'(2 * ((ref_crc(mc1) & 32'h1FF) >> 4)),
                  16'(1 << (ref_crc(mc1) & 32'hF)));
        cfg_write(2'd2, 32'h0020_0000);
        send_frame(mc1, "R8 hash hit", 0);
        send_frame(mc2, "R8 hash other", 0);
        for (int w = 0; w < 32; w++) ind_write(10'h200 + 10'(2 * w), 16'hFFFF);
        send_frame(48'hFFFF_FFFF_FFFF, "R7 bcast ignores hash", 0);
        for (int w = 0; w < 32; w++) ind_write(10'h200 + 10'(2 * w), 16'hA5C3 ^ 16'(w * 16'h1111));
        for (int t = 0; t < 8; t++)
            send_frame({8'(t * 37), 8'(t * 91), 8'h5E, 8'(t), 8'h00, 8'(8'h01 | 8'(t << 2))},
                       "R9 table pattern", 0);
        cfg_write(2'd2, 32'h0);
        send_frame(mc1, "R8 hash disabled", 0);

        // R10: all multicast
        cfg_write(2'd2, 32'h2000_0000);
        send_frame(mc2, "R10 all multicast", 0);
        send_frame(uc, "R10 unicast rejected", 0);

        // R11: promiscuous
        cfg_write(2'd2, 32'hF800_0000);
        send_frame(uc, "R11 promiscuous unicast", 0);

        // R4: abandoned frame produces no decision
        cfg_write(2'd2, 32'h0800_0000);
        for (int k = 0; k < 3; k++) put_byte(uc[8*k +: 8], k == 0);
        send_frame(sta, "R4 restart", 0);

        // R12: mode write inside a frame waits for the next frame
        exp_q.push_back(1'b0); tag_q.push_back("R12 old mode kept");
        for (int k = 0; k < 6; k++) begin
            put_byte(uc[8*k +: 8], k == 0);
            if (k == 2) cfg_write(2'd2, 32'h1000_0000);
            if (k == 5) cyc_q.push_back(cyc + 1);
        end
        pause(); pause();
        send_frame(uc, "R12 new mode applied", 0);

        repeat (4) pause();
        check("R3 all decisions seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule